// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog with Register Access

This block is a countdown watchdog that software controls through a small synchronous register port. Software loads a 10-bit initial tick value and clears a halt bit to start the count. Once running, it must restart the count at regular intervals by writing the reload register. An external tick strobe paces the count, and each tick stands for 0.6 seconds in the target system. A read of the reload register returns the live count.

When the count runs out, the block does not reset the system at once. The first expiry only sets a sticky timeout flag and restarts the count from the initial value. If a second expiry arrives while that flag is still set, the block raises a second-timeout flag and, unless the no-reboot bit is set, emits a one-cycle system reset request. Software that clears the first flag and reloads the count goes back to the start of the two-stage sequence.

Status flags are cleared by writing 1 to them. Initial values below 4 are rejected and leave the programmed value unchanged.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the count and the initial value are both 4, the control register reads 0x0801 (halt bit 11 = 1, no-reboot bit 0 = 1), both status registers read 0, and rst_req is low.
- R2: While the halt bit (control offset 0x08, bit 11) is 1, tick pulses leave the count unchanged.
- R3: While the block is not halted, each tick pulse lowers the count by one. Reading offset 0x00 returns the count in bits 9:0, with bits 15:10 reading 0.
- R4: A write of any data to offset 0x00 sets the count to the initial value. If a tick arrives in the same cycle, the reload takes priority and no expiry occurs.
- R5: A write to offset 0x12 stores bits 9:0 as the new initial value when that value is 4 or more. Values 0 to 3 are ignored and the old value is kept. Bits 15:10 of offset 0x12 always read 0.
- R6: A tick that arrives while the count is 0 and the block is running is an expiry. On the same edge the count reloads from the initial value. If the first-timeout flag (offset 0x04, bit 3) is clear, the expiry sets it.
- R7: An expiry that arrives while the first-timeout flag is already set sets the second-timeout flag (offset 0x06, bit 1). If no-reboot is 0, it also sets the boot flag (offset 0x06, bit 2) and drives rst_req high for exactly one cycle.
- R8: When no-reboot (offset 0x08, bit 0) is 1, a second expiry still sets the second-timeout flag, but rst_req stays low and the boot flag is not set.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an expiry sets a flag in the same cycle that software clears it, the set takes priority.
- R10: Clearing the first-timeout flag and reloading the count restarts the sequence, so the next expiry is treated as a first timeout only.
- R11: Read data appears on rdata in the cycle after rd_en. An address that is not mapped reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_stb | input | 1 | One-cycle pulse per watchdog tick |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench counts expiries exactly. It relies on the count taking N+1 ticks from a reload value N, so a design that expired at 1 instead of 0 would set the flags one tick early and fail the read-back. It checks that a second expiry with no-reboot set produces no reset pulse and no boot flag, which catches a design that ignores the veto. It drives an expiry in the same cycle as a write-one-to-clear of the first flag, which catches a design where the clear wins. It also confirms that clearing the flag plus a reload makes the next expiry a first stage again, so a design that kept stage state elsewhere would request a reset too early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned OFF_RELOAD = 'h00;
  localparam int unsigned OFF_STAT1  = 'h04;
  localparam int unsigned OFF_STAT2  = 'h06;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_INIT   = 'h12;

  localparam int unsigned POS_TOUT1    = 3;
  localparam int unsigned POS_TOUT2    = 1;
  localparam int unsigned POS_BOOT     = 2;
  localparam int unsigned POS_HALT     = 11;
  localparam int unsigned POS_NOREBOOT = 0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RELOAD, SEL_STAT1, SEL_STAT2, SEL_CTRL, SEL_INIT
  } reg_sel_e;

  // Accept a candidate initial value only when it reaches the floor.
  function automatic logic init_accept(input logic [15:0] cand,
                                       input int unsigned floor_v);
    return 32'(cand) >= floor_v;
  endfunction

  // Sticky flag update: a set event wins over a clear request.
  function automatic logic sticky_next(input logic cur, input logic set_ev,
                                       input logic clr_req);
    return set_ev | (cur & ~clr_req);
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned INIT_RST = 4,
  parameter int unsigned MIN_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  count,
  input  logic              tout1,
  input  logic              tout2,
  input  logic              boot,
  output logic [DATA_W-1:0] rdata,
  output logic              halt,
  output logic              no_reboot,
  output logic [CNT_W-1:0]  init_val,
  output logic              reload_wr,
  output logic              clr_tout1,
  output logic              clr_tout2,
  output logic              clr_boot
);

  localparam int unsigned PAD_W = DATA_W - CNT_W;

  reg_sel_e sel;
  logic [DATA_W-1:0] rd_mux;
  logic [CNT_W-1:0]  init_cand;
  logic              init_ok;

  always_comb begin
    if      (addr == ADDR_W'(OFF_RELOAD)) sel = SEL_RELOAD;
    else if (addr == ADDR_W'(OFF_STAT1))  sel = SEL_STAT1;
    else if (addr == ADDR_W'(OFF_STAT2))  sel = SEL_STAT2;
    else if (addr == ADDR_W'(OFF_CTRL))   sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFF_INIT))   sel = SEL_INIT;
    else                                  sel = SEL_NONE;
  end

  assign init_cand = wdata[CNT_W-1:0];
  assign init_ok   = init_accept(16'(init_cand), MIN_INIT);

  assign reload_wr = wr_en && (sel == SEL_RELOAD);
  assign clr_tout1 = wr_en && (sel == SEL_STAT1) && wdata[POS_TOUT1];
  assign clr_tout2 = wr_en && (sel == SEL_STAT2) && wdata[POS_TOUT2];
  assign clr_boot  = wr_en && (sel == SEL_STAT2) && wdata[POS_BOOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt      <= 1'b1;
      no_reboot <= 1'b1;
      init_val  <= CNT_W'(INIT_RST);
    end else if (wr_en) begin
      if (sel == SEL_CTRL) begin
        halt      <= wdata[POS_HALT];
        no_reboot <= wdata[POS_NOREBOOT];
      end
      if (sel == SEL_INIT && init_ok) init_val <= init_cand;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_RELOAD: rd_mux = {{PAD_W{1'b0}}, count};
      SEL_INIT:   rd_mux = {{PAD_W{1'b0}}, init_val};
      SEL_STAT1:  rd_mux[POS_TOUT1] = tout1;
      SEL_STAT2: begin
        rd_mux[POS_TOUT2] = tout2;
        rd_mux[POS_BOOT]  = boot;
      end
      SEL_CTRL: begin
        rd_mux[POS_HALT]     = halt;
        rd_mux[POS_NOREBOOT] = no_reboot;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned INIT_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic step;

  assign step   = tick && !halt;
  assign expire = step && (count == '0) && !reload_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= CNT_W'(INIT_RST);
    else if (reload_wr) count <= init_val;
    else if (expire)    count <= init_val;
    else if (step)      count <= count - 1'b1;
  end

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic no_reboot,
  input  logic clr_tout1,
  input  logic clr_tout2,
  input  logic clr_boot,
  output logic tout1,
  output logic tout2,
  output logic boot,
  output logic stage2,
  output logic rst_req
);

  logic fire;

  assign stage2 = expire && tout1;
  assign fire   = stage2 && !no_reboot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout1   <= 1'b0;
      tout2   <= 1'b0;
      boot    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      tout1   <= sticky_next(tout1, expire, clr_tout1);
      tout2   <= sticky_next(tout2, stage2, clr_tout2);
      boot    <= sticky_next(boot, fire, clr_boot);
      rst_req <= fire;
    end
  end

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned INIT_RST = 4,
  parameter int unsigned MIN_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] init_q;
  logic             halt_q;
  logic             noreboot_q;
  logic             reload_wr;
  logic             clr_tout1;
  logic             clr_tout2;
  logic             clr_boot;
  logic             expire_ev;
  logic             stage2_ev;
  logic             tout1_q;
  logic             tout2_q;
  logic             boot_q;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .INIT_RST(INIT_RST), .MIN_INIT(MIN_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .count(cnt_q), .tout1(tout1_q), .tout2(tout2_q),
    .boot(boot_q), .rdata(rdata), .halt(halt_q), .no_reboot(noreboot_q),
    .init_val(init_q), .reload_wr(reload_wr), .clr_tout1(clr_tout1),
    .clr_tout2(clr_tout2), .clr_boot(clr_boot)
  );

  wdog_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_stb), .halt(halt_q),
    .reload_wr(reload_wr), .init_val(init_q), .count(cnt_q),
    .expire(expire_ev)
  );

  wdog_escalate u_esc (
    .clk(clk), .rst_n(rst_n), .expire(expire_ev), .no_reboot(noreboot_q),
    .clr_tout1(clr_tout1), .clr_tout2(clr_tout2), .clr_boot(clr_boot),
    .tout1(tout1_q), .tout2(tout2_q), .boot(boot_q), .stage2(stage2_ev),
    .rst_req(rst_req)
  );

endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_INIT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init_val,
  input logic             halt,
  input logic             reload_wr,
  input logic             expire,
  input logic             tout1,
  input logic             tout2,
  input logic             no_reboot
);

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_wr) |=> count == $past(count)); // R2

  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    32'(init_val) >= MIN_INIT); // R5

  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(init_val)); // R6

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R7

  AST_RST_VETO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (tout2 && $past(!no_reboot))); // R8

  AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout2) |-> $past(tout1)); // R7

endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .count(cnt_q),
  .init_val(init_q), .halt(halt_q), .reload_wr(reload_wr),
  .expire(expire_ev), .tout1(tout1_q), .tout2(tout2_q),
  .no_reboot(noreboot_q)
);

// File: tb/wdog_twostage_test.sv
`timescale 1ns/1ps
module wdog_twostage_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_stb = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rdata;
  logic        rst_req;

  int tests = 0;
  int fails = 0;
  int rst_pulses = 0;
  logic rd_seen = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wdog_twostage uut (
    .clk(clk), .rst_n(rst_n), .tick_stb(tick_stb), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
    .rst_req(rst_req)
  );

  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) if (rst_req) rst_pulses++;

  // Monitor: compares each completed read against the scoreboard.
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=0x%04h expected=0x%04h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_stb = 1'b1;
      @(negedge clk); tick_stb = 1'b0;
    end
  endtask

  task automatic chk_pulses(input int e, input string t);
    @(negedge clk);
    tests++;
    if (rst_pulses != e) begin
      fails++;
      $display("FAIL %s: reset pulses=%0d expected=%0d", t, rst_pulses, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, 16'h0004, "R1 count");
    rd(5'h08, 16'h0801, "R1 ctrl");
    rd(5'h12, 16'h0004, "R1 init");
    rd(5'h04, 16'h0000, "R1 stat1");
    rd(5'h06, 16'h0000, "R1 stat2");
    chk_pulses(0, "R1 rst_req");

    // R2 halted ignores ticks
    ticks(3);
    rd(5'h00, 16'h0004, "R2 halted count");

    // R5 initial value programming
    wr(5'h12, 16'd10);
    rd(5'h12, 16'd10, "R5 accept 10");
    wr(5'h12, 16'd3);
    rd(5'h12, 16'd10, "R5 ignore 3");
    wr(5'h12, 16'hFC0C);
    rd(5'h12, 16'h000C, "R5 upper bits read 0");
    wr(5'h12, 16'd10);

    // R4 reload
    wr(5'h00, 16'hBEEF);
    rd(5'h00, 16'd10, "R4 reload");

    // R3 counting
    wr(5'h08, 16'h0000);
    ticks(3);
    rd(5'h00, 16'd7, "R3 count after 3 ticks");

    // R6 first expiry after N+1 ticks
    wr(5'h00, 16'h0000);
    ticks(10);
    rd(5'h04, 16'h0000, "R6 no expiry at zero");
    ticks(1);
    rd(5'h04, 16'h0008, "R6 first flag");
    rd(5'h00, 16'd10, "R6 reloaded");

    // R9 writing 0 leaves flag
    wr(5'h04, 16'h0000);
    rd(5'h04, 16'h0008, "R9 write 0 keeps");

    // R10 clear + reload restarts sequence
    wr(5'h04, 16'h0008);
    wr(5'h00, 16'h0000);
    rd(5'h04, 16'h0000, "R10 cleared");
    ticks(11);
    rd(5'h04, 16'h0008, "R10 first again");
    rd(5'h06, 16'h0000, "R10 no second");
    chk_pulses(0, "R10 no reset");

    // R7 second expiry with reboot allowed
    ticks(11);
    rd(5'h06, 16'h0006, "R7 second+boot");
    chk_pulses(1, "R7 one pulse");

    // R9 W1C per bit
    wr(5'h06, 16'h0002);
    rd(5'h06, 16'h0004, "R9 clear second");
    wr(5'h06, 16'h0004);
    rd(5'h06, 16'h0000, "R9 clear boot");

    // R8 no-reboot veto
    wr(5'h08, 16'h0001);
    ticks(11);
    rd(5'h06, 16'h0002, "R8 second no boot");
    chk_pulses(1, "R8 no pulse");

    // R11 unmapped and ctrl readback
    rd(5'h02, 16'h0000, "R11 unmapped");
    rd(5'h08, 16'h0001, "R11 ctrl");

    // R9 set wins over simultaneous clear
    wr(5'h04, 16'h0008);
    wr(5'h00, 16'h0000);
    ticks(10);
    @(negedge clk);
    tick_stb = 1'b1; addr = 5'h04; wdata = 16'h0008; wr_en = 1'b1;
    @(negedge clk);
    tick_stb = 1'b0; wr_en = 1'b0;
    rd(5'h04, 16'h0008, "R9 set wins");
    rd(5'h06, 16'h0002, "R9 stage one only");

    // R2 halt after running
    wr(5'h08, 16'h0800);
    ticks(2);
    rd(5'h00, 16'd10, "R2 halted again");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule